// File: doc/BRIEF.md
# Reset Cause and Boot Rollback Controller

This block keeps the reset history of a microcontroller-class system in retained registers and uses it to decide which firmware image the boot logic starts. A system reset is signalled to the block by a one-cycle `rst_evt` pulse, with `rst_by_wdt` and `rst_by_bor` marking whether a watchdog expiry and/or a supply brownout caused it. The block latches those causes so that startup software can read them, and counts watchdog resets inside a sliding window that is measured in ticks from a seconds strobe.

The boot target is one of two application banks or a protected golden image. Software stages a freshly written image in the inactive bank, which is accepted only while the external integrity flag `image_ok` is high. The following reset boots that bank as a trial. If a watchdog reset hits before software confirms the trial image, the next boot goes back to the previous bank. If watchdog resets arrive too quickly, the block locks onto the golden image. All retained state is cleared only by the power-on reset `por_n`. The boot selection changes only at a reset event.

Top module: `boot_guard_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), `boot_sel` is bank A (2'b00), `active_bank` is 0, `trial_pending` is 0, both cause flags are 0 and `wdt_count` is 0.
- R2: A reset event sets `cause_wdt` when `rst_by_wdt` is high and `cause_bor` when `rst_by_bor` is high. Set flags stay set through later reset events until a clear-cause command (`cmd_op` 2'b01) clears both.
- R3: Each reset event with `rst_by_wdt` high adds one to `wdt_count`, which saturates at 2**CNT_W-1.
- R4: Once `wdt_count` is non-zero, WIN_TICKS `sec_tick` pulses with no intervening watchdog reset clear it to 0. A watchdog reset restarts the window, so WIN_TICKS-1 ticks after it leave the count unchanged.
- R5: The watchdog reset that brings `wdt_count` to LOOP_N or more selects the golden image (`boot_sel` 2'b10). The golden selection persists through all later reset events and window expiry until power-on reset.
- R6: A stage command (`cmd_op` 2'b10) given while `image_ok` is high and no trial is pending makes the next reset event boot the inactive bank (`boot_sel` = {1'b0, ~active_bank}) with `trial_pending` set.
- R7: A stage command given while `image_ok` is low is ignored: the next reset event boots the active bank and `trial_pending` stays 0.
- R8: A watchdog reset event while `trial_pending` is set (and the golden image is not selected) boots the previous active bank and clears `trial_pending`.
- R9: A confirm command (`cmd_op` 2'b11) while `trial_pending` is set clears it and makes the trial bank the active bank. Later watchdog resets then keep booting that bank.
- R10: A reset event without a watchdog cause during a pending trial boots the trial bank again and keeps `trial_pending` set.
- R11: `boot_sel` only takes the values 2'b00, 2'b01 and 2'b10, and it changes only in the cycle after a reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; the only clear of retained state |
| rst_evt | input | 1 | One-cycle pulse: a system reset has taken place |
| rst_by_wdt | input | 1 | Cause qualifier with `rst_evt`: watchdog expiry |
| rst_by_bor | input | 1 | Cause qualifier with `rst_evt`: brownout |
| sec_tick | input | 1 | One-cycle strobe once per second |
| cmd_valid | input | 1 | Software command strobe |
| cmd_op | input | 2 | Command: 00 none, 01 clear causes, 10 stage, 11 confirm |
| image_ok | input | 1 | Integrity check of the staged image passed |
| boot_sel | output | 2 | Boot target: 00 bank A, 01 bank B, 10 golden |
| active_bank | output | 1 | Bank accepted as known good (0 = A, 1 = B) |
| trial_pending | output | 1 | Trial image booted and not yet confirmed |
| cause_wdt | output | 1 | Latched watchdog-reset cause |
| cause_bor | output | 1 | Latched brownout cause |
| wdt_count | output | CNT_W | Watchdog resets in the current window |

## Verification
The hardest situation to reach is a watchdog reset that lands while a trial is pending. It has to be told apart from the crash-loop limit and from a confirmed image. The bench first runs a staged trial through a non-watchdog reset, then a watchdog reset, with power-on resets in between so the count stays far below the limit. It then repeats the sequence with a confirm in the middle. Window expiry is reached by counting ticks to one short of the limit, then to the limit. A sweep of watchdog resets well past saturation checks each count arithmetically and checks the golden lock.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;
   typedef enum logic [1:0] {
      SEL_A    = 2'b00,
      SEL_B    = 2'b01,
      SEL_GOLD = 2'b10
   } boot_sel_e;

   typedef enum logic [1:0] {
      OP_NOP       = 2'b00,
      OP_CLR_CAUSE = 2'b01,
      OP_STAGE     = 2'b10,
      OP_CONFIRM   = 2'b11
   } cmd_op_e;
endpackage

// File: rtl/boot_cause_latch.sv
module boot_cause_latch #(
   parameter bit ACCUM = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_evt,
   input  logic wdt_in,
   input  logic bor_in,
   input  logic clr,
   output logic wdt_flag,
   output logic bor_flag
);
   generate
      if (ACCUM) begin : g_accum
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               wdt_flag <= 1'b0;
               bor_flag <= 1'b0;
            end else if (rst_evt) begin
               wdt_flag <= wdt_flag | wdt_in;
               bor_flag <= bor_flag | bor_in;
            end else if (clr) begin
               wdt_flag <= 1'b0;
               bor_flag <= 1'b0;
            end
         end
      end else begin : g_last
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               wdt_flag <= 1'b0;
               bor_flag <= 1'b0;
            end else if (rst_evt) begin
               wdt_flag <= wdt_in;
               bor_flag <= bor_in;
            end else if (clr) begin
               wdt_flag <= 1'b0;
               bor_flag <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/boot_rate_window.sv
module boot_rate_window #(
   parameter int CNT_W     = 4,
   parameter int LOOP_N    = 5,
   parameter int WIN_TICKS = 60
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             wdt_evt,
   input  logic             sec_tick,
   output logic [CNT_W-1:0] count,
   output logic             loop_hit
);
   localparam int                WIN_W   = $clog2(WIN_TICKS + 1);
   localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0]  HIT_AT  = CNT_W'(LOOP_N - 1);
   localparam logic [WIN_W-1:0]  WIN_END = WIN_W'(WIN_TICKS - 1);

   logic [WIN_W-1:0] win;

   assign loop_hit = wdt_evt && (count >= HIT_AT);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         count <= '0;
         win   <= '0;
      end else if (wdt_evt) begin
         if (count != CNT_MAX) count <= count + 1'b1;
         win <= '0;
      end else if (sec_tick && (count != '0)) begin
         if (win == WIN_END) begin
            count <= '0;
            win   <= '0;
         end else begin
            win <= win + 1'b1;
         end
      end
   end
endmodule

// File: rtl/boot_bank_select.sv
module boot_bank_select
   import boot_guard_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_evt,
   input  logic       wdt_in,
   input  logic       loop_hit,
   input  logic       stage_req,
   input  logic       image_ok,
   input  logic       confirm_req,
   output logic [1:0] boot_sel,
   output logic       active_bank,
   output logic       trial_pending
);
   logic staged;
   logic golden;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         boot_sel      <= SEL_A;
         active_bank   <= 1'b0;
         trial_pending <= 1'b0;
         staged        <= 1'b0;
         golden        <= 1'b0;
      end else if (rst_evt) begin
         staged <= 1'b0;
         if (golden || loop_hit) begin
            golden        <= 1'b1;
            boot_sel      <= SEL_GOLD;
            trial_pending <= 1'b0;
         end else if (staged || (trial_pending && !wdt_in)) begin
            boot_sel      <= active_bank ? SEL_A : SEL_B;
            trial_pending <= 1'b1;
         end else begin
            boot_sel      <= active_bank ? SEL_B : SEL_A;
            trial_pending <= 1'b0;
         end
      end else begin
         if (stage_req && image_ok && !trial_pending && !golden)
            staged <= 1'b1;
         if (confirm_req && trial_pending) begin
            trial_pending <= 1'b0;
            active_bank   <= ~active_bank;
         end
      end
   end
endmodule

// File: rtl/boot_guard_ctrl.sv
module boot_guard_ctrl
   import boot_guard_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int LOOP_N      = 5,
   parameter int WIN_TICKS   = 60,
   parameter bit ACCUM_CAUSE = 1'b1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_evt,
   input  logic             rst_by_wdt,
   input  logic             rst_by_bor,
   input  logic             sec_tick,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic             image_ok,
   output logic [1:0]       boot_sel,
   output logic             active_bank,
   output logic             trial_pending,
   output logic             cause_wdt,
   output logic             cause_bor,
   output logic [CNT_W-1:0] wdt_count
);
   initial begin
      assert (LOOP_N >= 1 && LOOP_N <= (2**CNT_W) - 1)
         else $error("LOOP_N must fit the saturating counter");
      assert (WIN_TICKS >= 2) else $error("WIN_TICKS must be at least 2");
   end

   logic cmd_live;
   logic loop_hit;

   assign cmd_live = cmd_valid && !rst_evt;

   boot_cause_latch #(.ACCUM(ACCUM_CAUSE)) u_cause (
      .clk      (clk),
      .por_n    (por_n),
      .rst_evt  (rst_evt),
      .wdt_in   (rst_by_wdt),
      .bor_in   (rst_by_bor),
      .clr      (cmd_live && (cmd_op == OP_CLR_CAUSE)),
      .wdt_flag (cause_wdt),
      .bor_flag (cause_bor)
   );

   boot_rate_window #(
      .CNT_W     (CNT_W),
      .LOOP_N    (LOOP_N),
      .WIN_TICKS (WIN_TICKS)
   ) u_rate (
      .clk      (clk),
      .por_n    (por_n),
      .wdt_evt  (rst_evt && rst_by_wdt),
      .sec_tick (sec_tick),
      .count    (wdt_count),
      .loop_hit (loop_hit)
   );

   boot_bank_select u_sel (
      .clk           (clk),
      .por_n         (por_n),
      .rst_evt       (rst_evt),
      .wdt_in        (rst_by_wdt),
      .loop_hit      (loop_hit),
      .stage_req     (cmd_live && (cmd_op == OP_STAGE)),
      .image_ok      (image_ok),
      .confirm_req   (cmd_live && (cmd_op == OP_CONFIRM)),
      .boot_sel      (boot_sel),
      .active_bank   (active_bank),
      .trial_pending (trial_pending)
   );
endmodule

// File: rtl/boot_guard_chk.sv
module boot_guard_chk
   import boot_guard_pkg::*;
#(
   parameter int CNT_W  = 4,
   parameter int LOOP_N = 5
) (
   input logic             clk,
   input logic             por_n,
   input logic             rst_evt,
   input logic             rst_by_wdt,
   input logic             sec_tick,
   input logic             cmd_valid,
   input logic [1:0]       cmd_op,
   input logic [1:0]       boot_sel,
   input logic             active_bank,
   input logic             trial_pending,
   input logic             cause_wdt,
   input logic             cause_bor,
   input logic [CNT_W-1:0] wdt_count
);
   localparam logic [CNT_W-1:0] HIT_AT = CNT_W'(LOOP_N - 1);

   assert_sel_legal_R11: assert property (@(posedge clk) disable iff (!por_n)
      boot_sel != 2'b11);

   assert_sel_stable_R11: assert property (@(posedge clk) disable iff (!por_n)
      !rst_evt |=> $stable(boot_sel));

   assert_cause_capture_R2: assert property (@(posedge clk) disable iff (!por_n)
      rst_evt && rst_by_wdt |=> cause_wdt);

   assert_cause_clear_R2: assert property (@(posedge clk) disable iff (!por_n)
      cmd_valid && (cmd_op == OP_CLR_CAUSE) && !rst_evt |=> !cause_wdt && !cause_bor);

   assert_count_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
      !rst_evt && !sec_tick |=> $stable(wdt_count));

   assert_golden_R5: assert property (@(posedge clk) disable iff (!por_n)
      rst_evt && rst_by_wdt && (wdt_count >= HIT_AT) |=> boot_sel == SEL_GOLD);

   assert_rollback_R8: assert property (@(posedge clk) disable iff (!por_n)
      rst_evt && rst_by_wdt && trial_pending && (wdt_count < HIT_AT) && (boot_sel != SEL_GOLD)
      |=> (boot_sel == {1'b0, active_bank}) && !trial_pending);
endmodule

bind boot_guard_ctrl boot_guard_chk #(.CNT_W(CNT_W), .LOOP_N(LOOP_N)) u_chk (.*);

// File: tb/sim_boot_guard_ctrl.sv
`timescale 1ns/100ps
module sim_boot_guard_ctrl;
   localparam int CNT_W = 4;
   localparam int LOOP_N = 5;
   localparam int WIN_TICKS = 60;
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic rst_evt = 1'b0, rst_by_wdt = 1'b0, rst_by_bor = 1'b0;
   logic sec_tick = 1'b0, cmd_valid = 1'b0, image_ok = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [1:0] boot_sel;
   logic active_bank, trial_pending, cause_wdt, cause_bor;
   logic [CNT_W-1:0] wdt_count;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   boot_guard_ctrl #(.CNT_W(CNT_W), .LOOP_N(LOOP_N), .WIN_TICKS(WIN_TICKS)) u0 (
      .clk(clk), .por_n(por_n), .rst_evt(rst_evt), .rst_by_wdt(rst_by_wdt),
      .rst_by_bor(rst_by_bor), .sec_tick(sec_tick), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .image_ok(image_ok), .boot_sel(boot_sel),
      .active_bank(active_bank), .trial_pending(trial_pending),
      .cause_wdt(cause_wdt), .cause_bor(cause_bor), .wdt_count(wdt_count));

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic power_on();
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); @(negedge clk); por_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic sys_reset(input logic w, input logic b);
      rst_evt = 1'b1; rst_by_wdt = w; rst_by_bor = b;
      @(negedge clk);
      rst_evt = 1'b0; rst_by_wdt = 1'b0; rst_by_bor = 1'b0;
   endtask

   task automatic command(input logic [1:0] op, input logic ok);
      cmd_valid = 1'b1; cmd_op = op; image_ok = ok;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00; image_ok = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         sec_tick = 1'b1; @(negedge clk);
         sec_tick = 1'b0; @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      power_on();
      check("R1 boot_sel", boot_sel, 0);
      check("R1 active_bank", active_bank, 0);
      check("R1 trial_pending", trial_pending, 0);
      check("R1 causes", {cause_wdt, cause_bor}, 0);
      check("R1 wdt_count", wdt_count, 0);

      // R2: brownout cause held through a plain reset, then cleared
      sys_reset(1'b0, 1'b1);
      check("R2 bor latched", {cause_wdt, cause_bor}, 1);
      sys_reset(1'b0, 1'b0);
      check("R2 bor held", {cause_wdt, cause_bor}, 1);
      sys_reset(1'b1, 1'b0);
      check("R2 both held", {cause_wdt, cause_bor}, 3);
      command(2'b01, 1'b0);
      check("R2 cleared", {cause_wdt, cause_bor}, 0);

      // R3/R5: watchdog reset sweep past saturation
      power_on();
      for (int i = 1; i <= CNT_MAX + 3; i++) begin
         sys_reset(1'b1, 1'b0);
         check("R3 count", wdt_count, (i > CNT_MAX) ? CNT_MAX : i);
         check("R5 select", boot_sel, (i >= LOOP_N) ? 2 : 0);
      end
      ticks(WIN_TICKS);
      check("R4 count cleared", wdt_count, 0);
      sys_reset(1'b0, 1'b0);
      check("R5 golden sticky", boot_sel, 2);

      // R4: window restart and expiry
      power_on();
      sys_reset(1'b1, 1'b0);
      ticks(WIN_TICKS - 1);
      check("R4 held before end", wdt_count, 1);
      sys_reset(1'b1, 1'b0);
      check("R4 second", wdt_count, 2);
      ticks(WIN_TICKS - 1);
      check("R4 restarted window", wdt_count, 2);
      ticks(1);
      check("R4 expired", wdt_count, 0);
      check("R11 no change without reset", boot_sel, 0);

      // R7: stage without integrity flag
      power_on();
      command(2'b10, 1'b0);
      sys_reset(1'b0, 1'b0);
      check("R7 boot_sel", boot_sel, 0);
      check("R7 trial_pending", trial_pending, 0);

      // R6/R10/R8: trial, re-boot, rollback
      command(2'b10, 1'b1);
      check("R11 stage no change", boot_sel, 0);
      sys_reset(1'b0, 1'b0);
      check("R6 boot_sel", boot_sel, 1);
      check("R6 trial_pending", trial_pending, 1);
      sys_reset(1'b0, 1'b1);
      check("R10 boot_sel", boot_sel, 1);
      check("R10 trial_pending", trial_pending, 1);
      sys_reset(1'b1, 1'b0);
      check("R8 boot_sel", boot_sel, 0);
      check("R8 trial_pending", trial_pending, 0);
      check("R8 active_bank", active_bank, 0);

      // R9: confirm keeps the new bank
      power_on();
      command(2'b10, 1'b1);
      sys_reset(1'b0, 1'b0);
      command(2'b11, 1'b0);
      check("R9 trial_pending", trial_pending, 0);
      check("R9 active_bank", active_bank, 1);
      check("R11 confirm no change", boot_sel, 1);
      sys_reset(1'b1, 1'b0);
      check("R9 boot after wdt", boot_sel, 1);
      command(2'b10, 1'b1);
      sys_reset(1'b0, 1'b0);
      check("R6 trial from B", boot_sel, 0);
      sys_reset(1'b1, 1'b0);
      check("R8 rollback to B", boot_sel, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule